// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a simple bus master read a serial NOR flash as if it were memory. Software first loads a memory command word that describes the flash read: the opcode, the number of address bytes, the number of dummy bytes and the data lane format. That write arms the engine. One cycle later a status flag reports that the engine is initialized. From then on, every bus read becomes one complete flash frame. The engine lowers chip select and sends the opcode, the low bytes of the bus address and the dummy bytes. It then collects four data bytes and returns them as one 32-bit word.

A status reset request takes the engine out of memory mode, aborts any frame in flight and returns the pins to the register-driven command sequencer. While memory mode is active, register command writes from that sequencer are refused. A bus read issued before initialization waits with ready low until the engine is armed.

Top module: `mflash_read_engine`

## Requirements
- R1: After reset, `stat_init`, `bus_ready`, `cmd_accept` and `spi_sck` are 0 and `spi_cs_n` is 1.
- R2: A `cfg_wr` with a frame value in `cfg_word[23:21]` of 2 to 5, made while not initialized, sets `stat_init` on the next cycle. The word supplies the opcode in [31:24], the address byte count (frame minus one), the dummy byte count in [18:16] and the lane format in [20:19].
- R3: A `cfg_wr` whose frame value is 0, 1, 6 or 7 is rejected and `stat_init` stays 0.
- R4: For each bus read, with `spi_cs_n` low, the engine shifts the opcode and then the low address bytes of `bus_addr`, most significant byte first. Each byte goes out MSB first on `spi_io_out[0]`, one bit per rising `spi_sck`.
- R5: Dummy bytes of 8 `spi_sck` cycles follow, with `spi_io_oe` all 0. Then come four data bytes. Lane format 1 takes 2 cycles per byte and samples `spi_io_in[3:0]`, high nibble first. Every other lane format takes 8 cycles per byte and samples `spi_io_in[1]`, MSB first.
- R6: The four data bytes are packed little-endian: the first byte received goes to `bus_rdata[7:0]`. `bus_ready` is a one-cycle pulse with the data, and `spi_cs_n` rises in the same cycle.
- R7: While `stat_init` is 0, a pending `bus_req` gets no `bus_ready` and `spi_cs_n` stays high. The read is served once initialization completes.
- R8: `rst_req` clears `stat_init` on the next cycle, aborts any frame in flight (`spi_cs_n` high on the next cycle) and returns no `bus_ready`.
- R9: `cmd_accept` pulses one cycle after a `cmd_wr` made while `stat_init` is 0. It stays 0 for a `cmd_wr` made while `stat_init` is 1.
- R10: A `cfg_wr` made while `stat_init` is 1 leaves the active command unchanged.
- R11: Whenever `spi_cs_n` is high, `spi_sck` is 0 and `spi_io_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the memory command word |
| cfg_word | input | 32 | Memory command word |
| rst_req | input | 1 | Status reset request: leave memory mode |
| cmd_wr | input | 1 | Register command write from the command sequencer |
| cmd_accept | output | 1 | Register command was accepted |
| stat_init | output | 1 | Memory mode initialized |
| bus_req | input | 1 | Bus read request, held until `bus_ready` |
| bus_addr | input | AW | Bus read byte address |
| bus_ready | output | 1 | Read data valid, one-cycle pulse |
| bus_rdata | output | 32 | Read data |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_io_out | output | 4 | Serial data out (lane 0 used) |
| spi_io_oe | output | 4 | Output enable per lane |
| spi_io_in | input | 4 | Serial data in |

## Verification
The assertions assume that the bus master holds `bus_req` and `bus_addr` steady until it sees `bus_ready`, and then drops the request within one cycle. They also assume that `rst_req` and `cfg_wr` are single-cycle strobes. The stimulus meets this: it drives every input on the falling clock edge and releases each request on the same falling edge where ready is seen. The flash model changes `spi_io_in` only between rising serial clock edges, so the value the engine samples is always settled.

// File: rtl/mflash_pkg.sv
package mflash_pkg;
  // Field positions in the memory command word (decoded by the config stage).
  localparam int OPC_LSB   = 24;
  localparam int FRM_LSB   = 21;
  localparam int LANE_LSB  = 19;
  localparam int DUMMY_LSB = 16;
  localparam int FRM_MIN   = 2;
  localparam int FRM_MAX   = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN, ST_FIN} fsm_t;

  typedef struct packed {
    logic [7:0] opcode;
    logic [2:0] abytes;
    logic [2:0] dummy;
    logic       quad;
  } mcfg_t;
endpackage

// File: rtl/mflash_cfg.sv
module mflash_cfg
  import mflash_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_word,
  input  logic        rst_req,
  input  logic        cmd_wr,
  output logic        init,
  output mcfg_t       cfg,
  output logic        cmd_accept
);
  logic [2:0] frame;
  logic       frame_ok;

  assign frame    = cfg_word[FRM_LSB +: 3];
  assign frame_ok = (frame >= 3'(FRM_MIN)) && (frame <= 3'(FRM_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      init       <= 1'b0;
      cfg        <= '0;
      cmd_accept <= 1'b0;
    end else begin
      cmd_accept <= cmd_wr & ~init;
      if (rst_req) begin
        init <= 1'b0;
      end else if (cfg_wr && !init && frame_ok) begin
        init       <= 1'b1;
        cfg.opcode <= cfg_word[OPC_LSB +: 8];
        cfg.abytes <= frame - 3'd1;
        cfg.dummy  <= cfg_word[DUMMY_LSB +: 3];
        cfg.quad   <= (cfg_word[LANE_LSB +: 2] == 2'd1);
      end
    end
  end

  // R3
  bad_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !init && !frame_ok) |=> !init);
  // R9
  cmd_block_chk: assert property (@(posedge clk) disable iff (rst)
    $past(init) |-> !cmd_accept);
  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (init && $past(init)) |-> $stable(cfg));
endmodule

// File: rtl/mflash_shift.sv
module mflash_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              start,
  input  logic              tx_en,
  input  logic              quad,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic [3:0]        io_in,
  output logic              sck,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              io_do,
  output logic              io_de
);
  localparam int CW = $clog2(BYTE_W + 1);

  logic              active, half;
  logic [CW-1:0]     beats;
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) rx_byte <= '0;
    else if (active && !half)
      rx_byte <= quad ? {rx_byte[BYTE_W-5:0], io_in} : {rx_byte[BYTE_W-2:0], io_in[1]};
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      active <= 1'b0;
      half   <= 1'b0;
      beats  <= '0;
      sh     <= '0;
      sck    <= 1'b0;
      done   <= 1'b0;
      io_do  <= 1'b0;
      io_de  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        half   <= 1'b0;
        beats  <= quad ? CW'(BYTE_W / 4) : CW'(BYTE_W);
        sh     <= tx_byte;
        io_do  <= tx_byte[BYTE_W-1];
        io_de  <= tx_en;
        sck    <= 1'b0;
      end else if (active) begin
        if (!half) begin
          sck  <= 1'b1;
          half <= 1'b1;
        end else begin
          sck  <= 1'b0;
          half <= 1'b0;
          if (beats == CW'(1)) begin
            active <= 1'b0;
            done   <= 1'b1;
            io_de  <= 1'b0;
            io_do  <= 1'b0;
          end else begin
            beats <= beats - CW'(1);
            sh    <= sh << 1;
            io_do <= sh[BYTE_W-2];
          end
        end
      end
    end
  end
endmodule

// File: rtl/mflash_read_engine.sv
module mflash_read_engine
  import mflash_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [31:0]   cfg_word,
  input  logic          rst_req,
  input  logic          cmd_wr,
  output logic          cmd_accept,
  output logic          stat_init,
  input  logic          bus_req,
  input  logic [AW-1:0] bus_addr,
  output logic          bus_ready,
  output logic [31:0]   bus_rdata,
  output logic          spi_cs_n,
  output logic          spi_sck,
  output logic [3:0]    spi_io_out,
  output logic [3:0]    spi_io_oe,
  input  logic [3:0]    spi_io_in
);
  localparam int KW = 5;

  mcfg_t         cfg;
  fsm_t          state;
  logic [KW-1:0] k_q, ab_k, d_first, k_last, sh_idx;
  logic [31:0]   addr_q, addr_sh;
  logic          in_data, tx_en, quad_now, start;
  logic [7:0]    tx_byte, rx_byte;
  logic          sh_sck, sh_done, sh_do, sh_de;

  mflash_cfg u_cfg (
    .clk, .rst, .cfg_wr, .cfg_word, .rst_req, .cmd_wr,
    .init(stat_init), .cfg, .cmd_accept
  );

  assign ab_k     = KW'(cfg.abytes);
  assign d_first  = KW'(1) + ab_k + KW'(cfg.dummy);
  assign k_last   = d_first + KW'(3);
  assign in_data  = (k_q >= d_first);
  assign tx_en    = (k_q <= ab_k);
  assign quad_now = cfg.quad && in_data;
  assign start    = (state == ST_LOAD);
  assign sh_idx   = ab_k - k_q;
  assign addr_sh  = addr_q >> {sh_idx, 3'b000};

  always_comb begin
    if (k_q == '0)  tx_byte = cfg.opcode;
    else if (tx_en) tx_byte = addr_sh[7:0];
    else            tx_byte = 8'h00;
  end

  mflash_shift #(.BYTE_W(8)) u_shift (
    .clk, .rst, .abort(rst_req), .start, .tx_en, .quad(quad_now),
    .tx_byte, .io_in(spi_io_in), .sck(sh_sck), .done(sh_done),
    .rx_byte, .io_do(sh_do), .io_de(sh_de)
  );

  assign spi_sck    = sh_sck;
  assign spi_io_out = {3'b000, sh_do};
  assign spi_io_oe  = {3'b000, sh_de};

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (!rst_req && state == ST_RUN && sh_done && in_data)
      bus_rdata <= {rx_byte, bus_rdata[31:8]};
  end

  always_ff @(posedge clk) begin
    if (rst || rst_req) begin
      state     <= ST_IDLE;
      spi_cs_n  <= 1'b1;
      bus_ready <= 1'b0;
      k_q       <= '0;
      if (rst) addr_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          bus_ready <= 1'b0;
          if (stat_init && bus_req) begin
            addr_q   <= 32'(bus_addr);
            k_q      <= '0;
            spi_cs_n <= 1'b0;
            state    <= ST_LOAD;
          end
        end
        ST_LOAD: state <= ST_RUN;
        ST_RUN: if (sh_done) begin
          if (k_q == k_last) begin
            spi_cs_n  <= 1'b1;
            bus_ready <= 1'b1;
            state     <= ST_FIN;
          end else begin
            k_q   <= k_q + KW'(1);
            state <= ST_LOAD;
          end
        end
        default: begin
          bus_ready <= 1'b0;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  // R11
  idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> (!spi_sck && spi_io_oe == 4'b0000));
  // R7
  no_init_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_init |-> spi_cs_n);
  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> !bus_ready);
  // R6
  ready_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ready) |-> $rose(spi_cs_n));
endmodule

// File: tb/mflash_read_engine_tb_top.sv
module mflash_read_engine_tb_top;
  localparam int AW = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0, rst_req = 1'b0, cmd_wr = 1'b0, bus_req = 1'b0;
  logic [31:0] cfg_word = '0;
  logic [AW-1:0] bus_addr = '0;
  logic [3:0] spi_io_in = '0;
  logic cmd_accept, stat_init, bus_ready, spi_cs_n, spi_sck;
  logic [31:0] bus_rdata;
  logic [3:0] spi_io_out, spi_io_oe;

  always #5 clk = ~clk;

  mflash_read_engine #(.AW(AW)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit chk_on = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference state
  bit m_init = 0, m_acc = 0, m_quad = 0;
  int m_ab = 0, m_dm = 0;
  logic [7:0] m_op = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_init <= 0; m_acc <= 0;
    end else begin
      m_acc <= cmd_wr && !m_init;
      if (rst_req) m_init <= 0;
      else if (cfg_wr && !m_init && cfg_word[23:21] >= 2 && cfg_word[23:21] <= 5) begin
        m_init <= 1;
        m_op   <= cfg_word[31:24];
        m_ab   <= int'(cfg_word[23:21]) - 1;
        m_dm   <= int'(cfg_word[18:16]);
        m_quad <= (cfg_word[20:19] == 2'd1);
      end
    end
  end

  function automatic logic [7:0] mb(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [3:0] beat_val(input int a, input int b, input bit q);
    logic [7:0] v;
    if (q) begin
      v = mb(a + b / 2);
      return (b % 2 == 0) ? v[7:4] : v[3:0];
    end
    v = mb(a + b / 8);
    return {2'b00, v[7 - b % 8], 1'b0};
  endfunction

  // Flash model, sampled on the falling clock edge
  int cur_addr = 0, rises = 0, last_rises = 0;
  logic [95:0] hdr = '0, last_hdr = '0;
  bit oe_bad = 0, last_oe_bad = 0, prev_sck = 0, prev_cs = 1;

  always @(negedge clk) begin
    int hb;
    hb = 8 * (1 + m_ab + m_dm);
    if (chk_on) begin
      check(stat_init == m_init, "R2/R3/R8 init", 64'(stat_init), 64'(m_init));
      check(cmd_accept == m_acc, "R9 accept", 64'(cmd_accept), 64'(m_acc));
      check(!spi_cs_n || (!spi_sck && spi_io_oe == 0), "R11 idle pins", 64'({spi_sck, spi_io_oe}), 64'(0));
      check(m_init || spi_cs_n, "R7 cs while not init", 64'(spi_cs_n), 64'(1));
    end
    if (spi_cs_n) begin
      if (!prev_cs) begin
        last_hdr = hdr; last_rises = rises; last_oe_bad = oe_bad;
      end
      rises = 0; hdr = '0; oe_bad = 0;
    end else if (spi_sck && !prev_sck) begin
      if (rises < hb) hdr = {hdr[94:0], spi_io_out[0]};
      if (rises >= 8 * (1 + m_ab) && spi_io_oe != 0) oe_bad = 1;
      rises++;
    end
    prev_sck = spi_sck;
    prev_cs  = spi_cs_n;
    spi_io_in = (rises >= hb) ? beat_val(cur_addr, rises - hb, m_quad) : 4'h0;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] op, input logic [2:0] frm, input logic [1:0] lane, input logic [2:0] dm);
    @(negedge clk);
    cfg_word = {op, frm, lane, dm, 16'h0000};
    cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic do_read(input int a);
    logic [63:0] exp_hdr, got_hdr, exp_d;
    int hb, beats;
    bit seen;
    seen = 0;
    cur_addr = a;
    bus_addr = AW'(a);
    bus_req = 1;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (bus_ready) seen = 1;
    end
    check(seen, "R6 ready seen", 64'(seen), 64'(1));
    exp_d = 64'({mb(a + 3), mb(a + 2), mb(a + 1), mb(a)});
    check(64'(bus_rdata) == exp_d, "R5/R6 data", 64'(bus_rdata), exp_d);
    check(spi_cs_n == 1, "R6 cs high with ready", 64'(spi_cs_n), 64'(1));
    bus_req = 0;
    @(negedge clk);
    check(bus_ready == 0, "R6 ready single pulse", 64'(bus_ready), 64'(0));
    hb = 8 * (1 + m_ab + m_dm);
    beats = m_quad ? 8 : 32;
    exp_hdr = (64'(m_op) << (8 * m_ab)) | (64'(a) & ((64'(1) << (8 * m_ab)) - 1));
    got_hdr = 64'(last_hdr >> (8 * m_dm)) & ((64'(1) << (8 * (1 + m_ab))) - 1);
    check(got_hdr == exp_hdr, "R4 opcode and address", got_hdr, exp_hdr);
    check(last_rises == hb + beats, "R5 sck count", 64'(last_rises), 64'(hb + beats));
    check(!last_oe_bad, "R5 oe low in dummy/data", 64'(last_oe_bad), 64'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(4);
    rst = 0;
    chk_on = 1;
    tick(1);
    // R1
    check(stat_init == 0 && bus_ready == 0 && cmd_accept == 0, "R1 reset outputs",
          64'({stat_init, bus_ready, cmd_accept}), 64'(0));
    check(spi_cs_n == 1 && spi_sck == 0, "R1 reset pins", 64'({spi_cs_n, spi_sck}), 64'(2));

    // R9: command accepted while not initialized
    cmd_wr = 1; tick(1); cmd_wr = 0;
    check(cmd_accept == 1, "R9 accept when idle", 64'(cmd_accept), 64'(1));

    // R7: pending read before init
    cur_addr = 32'h000100; bus_addr = AW'(32'h000100); bus_req = 1;
    tick(20);
    check(bus_ready == 0 && spi_cs_n == 1, "R7 held read", 64'({bus_ready, spi_cs_n}), 64'(1));

    // R3: rejected frames
    write_cfg(8'h0B, 3'd6, 2'd0, 3'd1); tick(1);
    check(stat_init == 0, "R3 frame 6", 64'(stat_init), 64'(0));
    write_cfg(8'h0B, 3'd1, 2'd0, 3'd1); tick(1);
    check(stat_init == 0, "R3 frame 1", 64'(stat_init), 64'(0));
    check(bus_ready == 0, "R7 still held", 64'(bus_ready), 64'(0));

    // R2: 3 address bytes, 1 dummy, single lane; held read is served
    write_cfg(8'h0B, 3'd4, 2'd0, 3'd1);
    check(stat_init == 1, "R2 init set", 64'(stat_init), 64'(1));
    do_read(32'h000100);
    do_read(32'hABCDEF);
    do_read(32'h123456);

    // R9 / R10 while initialized
    cmd_wr = 1; tick(1); cmd_wr = 0;
    check(cmd_accept == 0, "R9 refused when active", 64'(cmd_accept), 64'(0));
    write_cfg(8'hEB, 3'd5, 2'd1, 3'd3);
    do_read(32'h00F00D); // R10: header must still carry 0x0B, 3 address bytes

    // R8: leave, then quad lanes with 4 address bytes
    @(negedge clk); rst_req = 1; @(negedge clk); rst_req = 0;
    check(stat_init == 0, "R8 init cleared", 64'(stat_init), 64'(0));
    write_cfg(8'h6B, 3'd5, 2'd1, 3'd1);
    do_read(32'h00C0DE);
    do_read(32'hFFFFFC);

    // 1 address byte, no dummy
    @(negedge clk); rst_req = 1; @(negedge clk); rst_req = 0;
    write_cfg(8'h03, 3'd2, 2'd0, 3'd0);
    do_read(32'h1234AB);

    // R8: abort in the middle of a frame
    cur_addr = 32'h004400; bus_addr = AW'(32'h004400); bus_req = 1;
    tick(30);
    check(spi_cs_n == 0, "R8 frame in flight", 64'(spi_cs_n), 64'(0));
    rst_req = 1; @(negedge clk); rst_req = 0;
    check(spi_cs_n == 1 && stat_init == 0, "R8 abort", 64'({spi_cs_n, stat_init}), 64'(2));
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(bus_ready == 0, "R8 no ready after abort", 64'(bus_ready), 64'(0));
    end
    write_cfg(8'h3B, 3'd4, 2'd2, 3'd2);
    do_read(32'h004400);

    tick(5);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule